// File: doc/BRIEF.md
# Synchronous PWM Update Controller

This block manages double-buffered parameter updates for a group of PWM channels that all run from one shared period counter. Each channel has a shadow copy and an active copy of its period, dead-time and duty-cycle values. The group also shares a shadow and an active update-period value. Software and DMA write only the shadows. The block decides on which PWM period boundary each shadow moves into its active register, and every channel in the group moves on that same boundary.

There are two classes of update. Period and dead-time are copied only after software sets a self-clearing unlock bit. Duty-cycle and update-period are copied by an update-period counter, either automatically or, in the manual mode, together with the unlock event. A write-ready flag, a one-cycle interrupt pulse and a DMA request tell the writer when it may supply the next set of duty values. Waveform generation, dead-time insertion and the DMA engine are outside the block. The period boundary arrives as a one-cycle pulse, `period_tick`.

Top module: `spwm_update_ctrl`

## Requirements
- R1: After reset, all shadow and active values are 0, the update counter is 0, the unlock bit is 0, `wr_ready` is 1, and `ready_irq`, `dma_req`, `prd_load` and `duty_load` are 0.
- R2: Active period and dead-time values change only on a clock edge that closes a cycle with `period_tick`=1 while the unlock bit is 1. A shadow write alone is never applied. A copy uses the shadow values held before that cycle's writes.
- R3: Once set, `unlock` stays 1 until the next `period_tick`. It then clears in that edge, unless a new unlock write arrives in the same cycle. In that case it stays 1.
- R4: In mode code 0 (manual), duty shadows are copied together with period and dead-time on the unlock event. The update counter holds its value and the update-period active value does not change.
- R5: In mode codes 1, 2 and 3 (automatic), each `period_tick` either increments `upd_cnt` or, when `upd_cnt` equals the active update period, resets it to 0. In the resetting case the duty and update-period shadows are also copied. With update period N, this copy happens every N+1 ticks.
- R6: A new update-period shadow value becomes active only at the next automatic copy. The counter uses the new limit from then on.
- R7: `wr_ready` is set by every duty copy, and `ready_irq` pulses for exactly the cycle after that copy edge. `wr_ready` clears on an accepted duty write or on `stat_rd`. When a set and a clear happen in the same cycle, the set wins.
- R8: Mode code 0 or 1 accepts duty writes only from the bus. Mode code 2 or 3 accepts them only from `dma_wr`. A duty write from the other source has no effect.
- R9: `dma_req` equals `wr_ready` while the mode code is 2 or 3, and is 0 otherwise.
- R10: All channels receive a copy on the same edge. `prd_load` (period and dead-time) and `duty_load` (duty) are high during the first cycle in which the new active values are visible.
- R11: A bus write uses `wr_kind` codes 0 = period shadow, 1 = dead-time shadow, 2 = duty shadow, 3 = update-period shadow and 4 = unlock, with `wr_ch` selecting the channel. An unlock write sets the bit only when `wr_data[0]` is 1. Writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Update method code (0 manual, 1 automatic, 2/3 DMA) |
| period_tick | input | 1 | One-cycle PWM period boundary pulse |
| wr_en | input | 1 | Bus register write strobe |
| wr_kind | input | 3 | Bus write target code |
| wr_ch | input | CHW | Channel index for shadow writes |
| wr_data | input | PW | Bus write data |
| stat_rd | input | 1 | Status read strobe, clears ready flag |
| dma_wr | input | 1 | DMA duty write strobe |
| dma_ch | input | CHW | DMA target channel |
| dma_data | input | PW | DMA duty value |
| prd_act | output | NCH*PW | Active periods, channel i at [i*PW +: PW] |
| dt_act | output | NCH*DTW | Active dead-times |
| duty_act | output | NCH*PW | Active duty values |
| upr_act | output | UPW | Active update period |
| upd_cnt | output | UPW | Update-period counter |
| unlock | output | 1 | Unlock bit readback |
| wr_ready | output | 1 | Duty write-ready flag |
| ready_irq | output | 1 | One-cycle pulse when ready is set |
| dma_req | output | 1 | DMA request |
| prd_load | output | 1 | Period/dead-time copy indicator |
| duty_load | output | 1 | Duty copy indicator |

## Verification
Some rules are checked on every cycle by assertions. Active period, dead-time, duty and update-period values must stay unchanged without their copy strobe. The counter must never pass its active limit. The unlock bit must hold until a boundary and then clear. The ready flag must drop after a clear with no competing set. Other behaviours depend on timing across many boundaries and only the bench's scenarios show them: the N+1 copy spacing, a new update period taking effect only after the following copy, a duty write from the wrong source being ignored, and a set beating a clear on the ready flag. The bench covers these by comparing every output on every cycle against a behavioural model, in both directed sequences and a long random run that mixes modes.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
    typedef enum logic [2:0] {
        WK_PRD    = 3'd0,
        WK_DT     = 3'd1,
        WK_DUTY   = 3'd2,
        WK_UPR    = 3'd3,
        WK_UNLOCK = 3'd4
    } wkind_e;

    function automatic logic mode_is_auto(input logic [1:0] m);
        return m != 2'd0;
    endfunction

    function automatic logic mode_is_dma(input logic [1:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/spwm_chan_regs.sv
module spwm_chan_regs #(
    parameter int PW  = 16,
    parameter int DTW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prd_we,
    input  logic           dt_we,
    input  logic           duty_we,
    input  logic [PW-1:0]  cfg_wdata,
    input  logic [PW-1:0]  duty_wdata,
    input  logic           load_pd,
    input  logic           load_duty,
    output logic [PW-1:0]  prd_act,
    output logic [DTW-1:0] dt_act,
    output logic [PW-1:0]  duty_act
);
    typedef struct packed {
        logic [PW-1:0]  prd_sh;
        logic [DTW-1:0] dt_sh;
        logic [PW-1:0]  duty_sh;
        logic [PW-1:0]  prd;
        logic [DTW-1:0] dt;
        logic [PW-1:0]  duty;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_pd) begin
            st_d.prd = st_q.prd_sh;
            st_d.dt  = st_q.dt_sh;
        end
        if (load_duty) st_d.duty = st_q.duty_sh;
        if (prd_we)  st_d.prd_sh  = cfg_wdata;
        if (dt_we)   st_d.dt_sh   = cfg_wdata[DTW-1:0];
        if (duty_we) st_d.duty_sh = duty_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prd_act  = st_q.prd;
    assign dt_act   = st_q.dt;
    assign duty_act = st_q.duty;

    // R2
    prd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pd |=> $stable(prd_act) && $stable(dt_act));
    // R5
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_duty |=> $stable(duty_act));
endmodule

// File: rtl/spwm_upr_timer.sv
module spwm_upr_timer #(
    parameter int UPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           auto_en,
    input  logic           upr_we,
    input  logic [UPW-1:0] upr_wdata,
    output logic           fire,
    output logic [UPW-1:0] upr_act,
    output logic [UPW-1:0] cnt
);
    typedef struct packed {
        logic [UPW-1:0] upr_sh;
        logic [UPW-1:0] upr;
        logic [UPW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = tick && auto_en && (st_q.cnt == st_q.upr);
        if (wrap) begin
            st_d.cnt = '0;
            st_d.upr = st_q.upr_sh;
        end else if (tick && auto_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (upr_we) st_d.upr_sh = upr_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire    = wrap;
    assign upr_act = st_q.upr;
    assign cnt     = st_q.cnt;

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= upr_act);
    // R6
    upr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(upr_act));
    // R4
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> $stable(cnt));
endmodule

// File: rtl/spwm_ready_flag.sv
module spwm_ready_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic dma_mode,
    output logic ready,
    output logic irq,
    output logic dma_req
);
    typedef struct packed {
        logic ready;
        logic irq;
    } rdy_t;

    rdy_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = set_evt;
        if (set_evt)      st_d.ready = 1'b1;
        else if (clr_evt) st_d.ready = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ready: 1'b1, irq: 1'b0};
        else        st_q <= st_d;
    end

    assign ready   = st_q.ready;
    assign irq     = st_q.irq;
    assign dma_req = st_q.ready && dma_mode;

    // R7
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !ready);
    // R7
    irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready);
endmodule

// File: rtl/spwm_update_ctrl.sv
module spwm_update_ctrl #(
    parameter int NCH = 4,
    parameter int PW  = 16,
    parameter int DTW = 12,
    parameter int UPW = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic               period_tick,
    input  logic               wr_en,
    input  logic [2:0]         wr_kind,
    input  logic [CHW-1:0]     wr_ch,
    input  logic [PW-1:0]      wr_data,
    input  logic               stat_rd,
    input  logic               dma_wr,
    input  logic [CHW-1:0]     dma_ch,
    input  logic [PW-1:0]      dma_data,
    output logic [NCH*PW-1:0]  prd_act,
    output logic [NCH*DTW-1:0] dt_act,
    output logic [NCH*PW-1:0]  duty_act,
    output logic [UPW-1:0]     upr_act,
    output logic [UPW-1:0]     upd_cnt,
    output logic               unlock,
    output logic               wr_ready,
    output logic               ready_irq,
    output logic               dma_req,
    output logic               prd_load,
    output logic               duty_load
);
    import spwm_pkg::*;

    typedef struct packed {
        logic unlock;
        logic prd_load;
        logic duty_load;
    } top_t;

    top_t st_d, st_q;

    logic auto_en, dma_mode;
    logic unlock_set, load_pd, load_duty, fire;
    logic upr_we;
    logic [NCH-1:0] prd_we, dt_we, duty_we, bus_duty, dma_duty;
    logic duty_accept;

    assign auto_en    = mode_is_auto(mode);
    assign dma_mode   = mode_is_dma(mode);
    assign unlock_set = wr_en && (wr_kind == WK_UNLOCK) && wr_data[0];
    assign upr_we     = wr_en && (wr_kind == WK_UPR);
    assign load_pd    = period_tick && st_q.unlock;
    assign load_duty  = auto_en ? fire : load_pd;

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign prd_we[i]   = wr_en && (wr_kind == WK_PRD) && (wr_ch == CHW'(i));
        assign dt_we[i]    = wr_en && (wr_kind == WK_DT)  && (wr_ch == CHW'(i));
        assign bus_duty[i] = wr_en && (wr_kind == WK_DUTY) && (wr_ch == CHW'(i)) && !dma_mode;
        assign dma_duty[i] = dma_wr && (dma_ch == CHW'(i)) && dma_mode;
        assign duty_we[i]  = bus_duty[i] || dma_duty[i];
    end

    assign duty_accept = |duty_we;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        spwm_chan_regs #(.PW(PW), .DTW(DTW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .prd_we     (prd_we[i]),
            .dt_we      (dt_we[i]),
            .duty_we    (duty_we[i]),
            .cfg_wdata  (wr_data),
            .duty_wdata (dma_mode ? dma_data : wr_data),
            .load_pd    (load_pd),
            .load_duty  (load_duty),
            .prd_act    (prd_act[i*PW +: PW]),
            .dt_act     (dt_act[i*DTW +: DTW]),
            .duty_act   (duty_act[i*PW +: PW])
        );
    end

    spwm_upr_timer #(.UPW(UPW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (period_tick),
        .auto_en   (auto_en),
        .upr_we    (upr_we),
        .upr_wdata (wr_data[UPW-1:0]),
        .fire      (fire),
        .upr_act   (upr_act),
        .cnt       (upd_cnt)
    );

    spwm_ready_flag u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (load_duty),
        .clr_evt  (duty_accept || stat_rd),
        .dma_mode (dma_mode),
        .ready    (wr_ready),
        .irq      (ready_irq),
        .dma_req  (dma_req)
    );

    always_comb begin
        st_d           = st_q;
        st_d.prd_load  = load_pd;
        st_d.duty_load = load_duty;
        if (unlock_set)   st_d.unlock = 1'b1;
        else if (load_pd) st_d.unlock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlock    = st_q.unlock;
    assign prd_load  = st_q.prd_load;
    assign duty_load = st_q.duty_load;

    // R3
    unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && !period_tick) |=> unlock);
    // R3
    unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && period_tick && !unlock_set) |=> !unlock);
    // R2
    prd_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |=> !prd_load);
endmodule

// File: tb/spwm_update_ctrl_tb.sv
module spwm_update_ctrl_tb;
    localparam int NCH = 4, PW = 16, DTW = 12, UPW = 4, CHW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic period_tick = 1'b0, wr_en = 1'b0, stat_rd = 1'b0, dma_wr = 1'b0;
    logic [2:0] wr_kind = 3'd0;
    logic [CHW-1:0] wr_ch = '0, dma_ch = '0;
    logic [PW-1:0] wr_data = '0, dma_data = '0;
    logic [NCH*PW-1:0] prd_act, duty_act;
    logic [NCH*DTW-1:0] dt_act;
    logic [UPW-1:0] upr_act, upd_cnt;
    logic unlock, wr_ready, ready_irq, dma_req, prd_load, duty_load;

    always #4 clk = ~clk;

    spwm_update_ctrl #(.NCH(NCH), .PW(PW), .DTW(DTW), .UPW(UPW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .period_tick(period_tick),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_ch(wr_ch), .wr_data(wr_data),
        .stat_rd(stat_rd), .dma_wr(dma_wr), .dma_ch(dma_ch), .dma_data(dma_data),
        .prd_act(prd_act), .dt_act(dt_act), .duty_act(duty_act),
        .upr_act(upr_act), .upd_cnt(upd_cnt), .unlock(unlock),
        .wr_ready(wr_ready), .ready_irq(ready_irq), .dma_req(dma_req),
        .prd_load(prd_load), .duty_load(duty_load));

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // behavioural model state
    int m_prd_sh[NCH], m_dt_sh[NCH], m_duty_sh[NCH];
    int m_prd[NCH], m_dt[NCH], m_duty[NCH];
    int m_upr_sh, m_upr, m_cnt;
    bit m_unl, m_rdy, m_irq, m_pl, m_dl;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_prd_sh[i] = 0; m_dt_sh[i] = 0; m_duty_sh[i] = 0;
                m_prd[i] = 0; m_dt[i] = 0; m_duty[i] = 0;
            end
            m_upr_sh = 0; m_upr = 0; m_cnt = 0;
            m_unl = 0; m_rdy = 1; m_irq = 0; m_pl = 0; m_dl = 0;
        end else begin
            bit autom, dmam, ldpd, fire, lddu, acc;
            autom = (mode != 0);
            dmam  = mode[1];
            ldpd  = period_tick && m_unl;
            fire  = period_tick && autom && (m_cnt == m_upr);
            lddu  = autom ? fire : ldpd;
            acc   = (wr_en && wr_kind == 3'd2 && !dmam) || (dma_wr && dmam);
            for (int i = 0; i < NCH; i++) begin
                if (ldpd) begin m_prd[i] = m_prd_sh[i]; m_dt[i] = m_dt_sh[i]; end
                if (lddu) m_duty[i] = m_duty_sh[i];
            end
            if (fire) begin m_upr = m_upr_sh; m_cnt = 0; end
            else if (period_tick && autom) m_cnt = (m_cnt + 1) % 16;
            if (wr_en && wr_kind == 3'd4 && wr_data[0]) m_unl = 1;
            else if (ldpd) m_unl = 0;
            if (wr_en) begin
                case (wr_kind)
                    3'd0: m_prd_sh[wr_ch] = wr_data;
                    3'd1: m_dt_sh[wr_ch]  = wr_data % 4096;
                    3'd2: if (!dmam) m_duty_sh[wr_ch] = wr_data;
                    3'd3: m_upr_sh = wr_data % 16;
                    default: ;
                endcase
            end
            if (dma_wr && dmam) m_duty_sh[dma_ch] = dma_data;
            m_irq = lddu;
            if (lddu) m_rdy = 1;
            else if (acc || stat_rd) m_rdy = 0;
            m_pl = ldpd; m_dl = lddu;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) begin
                chk(prd_act[i*PW +: PW] == m_prd[i], "R2 prd", prd_act[i*PW +: PW], m_prd[i]);
                chk(dt_act[i*DTW +: DTW] == m_dt[i], "R2 dt", dt_act[i*DTW +: DTW], m_dt[i]);
                chk(duty_act[i*PW +: PW] == m_duty[i], "R5 duty", duty_act[i*PW +: PW], m_duty[i]);
            end
            chk(upd_cnt == m_cnt, "R5 cnt", upd_cnt, m_cnt);
            chk(upr_act == m_upr, "R6 upr", upr_act, m_upr);
            chk(unlock == m_unl, "R3 unlock", unlock, m_unl);
            chk(wr_ready == m_rdy, "R7 ready", wr_ready, m_rdy);
            chk(ready_irq == m_irq, "R7 irq", ready_irq, m_irq);
            chk(dma_req == (m_rdy && mode[1]), "R9 dma_req", dma_req, m_rdy && mode[1]);
            chk(prd_load == m_pl, "R10 prd_load", prd_load, m_pl);
            chk(duty_load == m_dl, "R10 duty_load", duty_load, m_dl);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [2:0] k, input int ch, input int d);
        wr_en = 1; wr_kind = k; wr_ch = CHW'(ch); wr_data = PW'(d);
        cyc(1);
        wr_en = 0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int t = 0; t < n; t++) begin
            period_tick = 1; cyc(1); period_tick = 0; cyc(gap);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(wr_ready == 1 && unlock == 0 && upd_cnt == 0 && prd_act == 0 && dma_req == 0,
            "R1 reset", {wr_ready, unlock}, 2);
        #1;
        // manual mode, R2 R4 R11
        mode = 2'd0;
        for (int i = 0; i < NCH; i++) begin
            bus_wr(3'd0, i, 100 + i);
            bus_wr(3'd1, i, 10 + i);
            bus_wr(3'd2, i, 50 + i);
        end
        ticks(3, 2);
        @(negedge clk);
        chk(prd_act[0 +: PW] == 0, "R2 no unlock", prd_act[0 +: PW], 0);
        #1;
        bus_wr(3'd4, 0, 1);
        cyc(2);
        @(negedge clk);
        chk(unlock == 1, "R3 held", unlock, 1);
        #1;
        ticks(1, 0);
        @(negedge clk);
        chk(prd_act[PW +: PW] == 101, "R2 copy", prd_act[PW +: PW], 101);
        chk(dt_act[DTW +: DTW] == 11, "R2 dt copy", dt_act[DTW +: DTW], 11);
        chk(duty_act[2*PW +: PW] == 52, "R4 duty with unlock", duty_act[2*PW +: PW], 52);
        chk(upd_cnt == 0 && unlock == 0, "R4 counter held", upd_cnt, 0);
        #1;
        bus_wr(3'd4, 0, 0);
        @(negedge clk);
        chk(unlock == 0, "R11 unlock write 0", unlock, 0);
        #1;
        // automatic mode, R5 R6
        mode = 2'd1;
        bus_wr(3'd3, 0, 1);
        bus_wr(3'd2, 0, 200);
        ticks(1, 1);
        @(negedge clk);
        chk(upr_act == 1 && duty_act[0 +: PW] == 200, "R6 upr applied", upr_act, 1);
        #1;
        bus_wr(3'd2, 0, 201);
        ticks(1, 1);
        @(negedge clk);
        chk(duty_act[0 +: PW] == 200, "R5 wait", duty_act[0 +: PW], 200);
        #1;
        ticks(1, 1);
        @(negedge clk);
        chk(duty_act[0 +: PW] == 201, "R5 second period", duty_act[0 +: PW], 201);
        #1;
        stat_rd = 1; cyc(1); stat_rd = 0;
        @(negedge clk);
        chk(wr_ready == 0, "R7 status read clear", wr_ready, 0);
        #1;
        bus_wr(3'd3, 0, 3);
        ticks(6, 1);
        // DMA mode, R8 R9
        mode = 2'd2;
        bus_wr(3'd2, 1, 300);
        dma_wr = 1; dma_ch = 2'd1; dma_data = 16'd400; cyc(1); dma_wr = 0;
        ticks(4, 1);
        @(negedge clk);
        chk(duty_act[PW +: PW] == 400, "R8 dma source", duty_act[PW +: PW], 400);
        chk(dma_req == 1, "R9 request", dma_req, 1);
        #1;
        // mixed random run
        for (int c = 0; c < 4000; c++) begin
            int unsigned r;
            r = $urandom;
            if (c % 300 == 0) mode = 2'((r >> 24) % 4);
            period_tick = (r % 5) == 0;
            wr_en   = ((r >> 4) % 3) == 0;
            wr_kind = 3'((r >> 8) % 5);
            wr_ch   = CHW'(r >> 13);
            wr_data = PW'(r >> 15);
            stat_rd = ((r >> 12) % 11) == 0;
            dma_wr  = ((r >> 20) % 4) == 0;
            dma_ch  = CHW'(r >> 22);
            dma_data = PW'(r ^ (r >> 7));
            cyc(1);
        end
        period_tick = 0; wr_en = 0; stat_rd = 0; dma_wr = 0;
        cyc(2);
        @(negedge clk);
        finish_run();
    end
endmodule